// File: doc/BRIEF.md
# Round-Robin Serial ADC Channel Scanner

This block reads an external eight-input, 10-bit serial converter over an SPI master link, with no help from software. It visits the inputs in a fixed circular order. For each input it pulls chip select low and waits a setup interval. It then clocks one 16-bit frame. The frame carries a command that selects a single-ended input and, in the same frame, collects the converter's reply.

The low 10 bits of the reply go into a per-input result register. Chip select is released in the cycle the result is written. After a fixed idle gap the next input is started.

Results can be read at any time through a channel-indexed read port. Each update is announced by a one-cycle strobe that carries the input number. Dropping the enable input lets the frame in flight complete and then parks the link with chip select high.

Top module: `adc_scanner`

## Requirements
- R1: After reset every result register reads 0xFFFF, chip select is high and SCK is low.
- R2: While enable is low after reset, chip select stays high. The first frame after enable addresses input 0.
- R3: Inputs are scanned 0,1,...,7 and then wrap to 0. Each stored result raises vld_o for exactly one cycle with vld_ch_o equal to the input just converted.
- R4: Each frame is 16 bits, MSB first. The command word has bit 8 = 1 (start), bit 7 = 0 (single-ended), the input number in bits 6:4, and all other bits 0.
- R5: The SPI timing is mode 0. SCK idles low and its period is SCK_DIV clock cycles, high for SCK_DIV/2 of them. MOSI changes after falling edges, and MISO is taken at rising edges.
- R6: A stored result holds bits 9:0 of the received word in bits 9:0 of the register. Bits 15:10 read 0, whatever the converter returned in the upper six positions.
- R7: At least CS_SETUP clock cycles pass between chip select falling and the first SCK rising edge.
- R8: Chip select rises on the same clock edge that writes the result and raises vld_o.
- R9: Between two frames, chip select stays high for exactly GAP_CYCLES clock cycles (25 cycles, which is 500 ns at 50 MHz).
- R10: If enable falls during a frame, that frame completes and its result is stored. Chip select then stays high. When enable returns, scanning resumes at the next input in order.
- R11: The read port returns the register selected by rd_ch_i in the same cycle. An input not yet converted still reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Scan enable |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data to converter |
| miso_i | input | 1 | SPI data from converter |
| cs_no | output | 1 | Converter chip select, active low |
| rd_ch_i | input | 3 | Result register select |
| rd_data_o | output | 16 | Selected result register |
| vld_o | output | 1 | One-cycle strobe on result update |
| vld_ch_o | output | 3 | Input number of the updated result |

## Verification
The hardest case to reach from the ports is enable falling while a frame is in flight. The stimulus watches chip select, waits for the frame of input 0 to begin, and drops enable inside it. The bench then expects that frame to complete and expects no further frame for several hundred cycles. After enable returns, the next stored input must be 1. The converter model returns replies whose upper six bits are non-zero, so masking is tested on every frame. It also changes MISO only after the rising edge the master samples on, so a master sampling on the wrong edge reads shifted data.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_W   = 16;
  localparam int CH_W      = 3;
  localparam int START_BIT = 8;
  localparam int MODE_BIT  = 7;
  localparam int CH_LSB    = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_GAP
  } scan_st_e;
endpackage

// File: rtl/adc_spi_shifter.sv
module adc_spi_shifter #(
  parameter int FRAME_W = 16,
  parameter int SCK_DIV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o
);
  localparam int PH_W  = $clog2(SCK_DIV);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(SCK_DIV/2 - 1);
  localparam logic [PH_W-1:0]  PH_HALF   = PH_W'(SCK_DIV/2);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(SCK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_W - 1);

  logic               busy_q;
  logic [PH_W-1:0]    ph_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] tx_q, rx_q;
  logic               done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
        bit_q  <= '0;
        tx_q   <= tx_i;
      end else if (busy_q) begin
        ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        // rising SCK follows this edge: sample here
        if (ph_q == PH_SAMPLE) rx_q <= {rx_q[FRAME_W-2:0], miso_i};
        // falling SCK follows this edge: advance MOSI here
        if (ph_q == PH_LAST) begin
          if (bit_q == BIT_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sck_o  = busy_q && (ph_q >= PH_HALF);
  assign mosi_o = busy_q && tx_q[FRAME_W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CS_SETUP   = 13,
  parameter int GAP_CYCLES = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               done_i,
  output logic               start_o,
  output logic [FRAME_W-1:0] cmd_o,
  output logic               cs_no,
  output logic               store_o,
  output logic [CH_W-1:0]    ch_o
);
  localparam int MAXC  = (CS_SETUP > GAP_CYCLES) ? CS_SETUP : GAP_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(CS_SETUP - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYCLES - 1);

  scan_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  ch_q;
  logic             cs_q;

  assign start_o = (st_q == ST_SETUP) && (cnt_q == SETUP_LAST);
  assign store_o = (st_q == ST_SHIFT) && done_i;
  assign cs_no   = cs_q;
  assign ch_o    = ch_q;

  always_comb begin
    cmd_o                    = '0;
    cmd_o[START_BIT]         = 1'b1;
    cmd_o[MODE_BIT]          = 1'b0;
    cmd_o[CH_LSB +: CH_W]    = ch_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ch_q  <= '0;
      cs_q  <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (en_i) begin
          st_q  <= ST_SETUP;
          cnt_q <= '0;
          cs_q  <= 1'b0;
        end
        ST_SETUP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == SETUP_LAST) st_q <= ST_SHIFT;
        end
        ST_SHIFT: if (done_i) begin
          st_q  <= ST_GAP;
          cnt_q <= '0;
          cs_q  <= 1'b1;
          ch_q  <= ch_q + 1'b1;   // power-of-two channel count wraps
        end
        ST_GAP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == GAP_LAST) begin
            cnt_q <= '0;
            if (en_i) begin
              st_q <= ST_SETUP;
              cs_q <= 1'b0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CH_W-1:0]    wr_ch_i,
  input  logic [FRAME_W-1:0] wr_word_i,
  input  logic [CH_W-1:0]    rd_ch_i,
  output logic [FRAME_W-1:0] rd_data_o
);
  localparam int N_CH = 1 << CH_W;
  localparam logic [FRAME_W-1:0] KEEP = FRAME_W'((1 << DATA_W) - 1);

  logic [FRAME_W-1:0] res_q [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  res_q[g] <= '1;
      else if (wr_en_i && (wr_ch_i == CH_W'(g)))    res_q[g] <= wr_word_i & KEEP;
    end
  end

  assign rd_data_o = res_q[rd_ch_i];
endmodule

// File: rtl/adc_scanner.sv
module adc_scanner
  import adc_scan_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int SCK_DIV    = 4,
  parameter int CS_SETUP   = 13,
  parameter int GAP_CYCLES = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               cs_no,
  input  logic [CH_W-1:0]    rd_ch_i,
  output logic [FRAME_W-1:0] rd_data_o,
  output logic               vld_o,
  output logic [CH_W-1:0]    vld_ch_o
);
  logic               start, done, store;
  logic [FRAME_W-1:0] cmd, rx;
  logic [CH_W-1:0]    ch;
  logic               vld_q;
  logic [CH_W-1:0]    vld_ch_q;

  adc_scan_seq #(.CS_SETUP(CS_SETUP), .GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk_i, .rst_ni, .en_i,
    .done_i(done), .start_o(start), .cmd_o(cmd),
    .cs_no, .store_o(store), .ch_o(ch)
  );

  adc_spi_shifter #(.FRAME_W(FRAME_W), .SCK_DIV(SCK_DIV)) u_spi (
    .clk_i, .rst_ni,
    .start_i(start), .tx_i(cmd), .miso_i,
    .sck_o, .mosi_o, .done_o(done), .rx_o(rx)
  );

  adc_result_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(store), .wr_ch_i(ch), .wr_word_i(rx),
    .rd_ch_i, .rd_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      vld_ch_q <= '0;
    end else begin
      vld_q    <= store;
      vld_ch_q <= ch;
    end
  end

  assign vld_o    = vld_q;
  assign vld_ch_o = vld_ch_q;
endmodule

// File: rtl/adc_scanner_chk.sv
module adc_scanner_chk
  import adc_scan_pkg::*;
#(
  parameter int CS_SETUP   = 13,
  parameter int GAP_CYCLES = 25
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_no,
  input logic            sck_o,
  input logic            vld_o,
  input logic [CH_W-1:0] vld_ch_o
);
  localparam int MAXC  = (CS_SETUP > GAP_CYCLES) ? CS_SETUP : GAP_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAXC);

  logic [CNT_W-1:0] lo_cnt, hi_cnt;
  logic [CH_W-1:0]  nxt_ch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= CMAX;
      nxt_ch <= '0;
    end else begin
      lo_cnt <= cs_no ? '0 : ((lo_cnt == CMAX) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !cs_no ? '0 : ((hi_cnt == CMAX) ? hi_cnt : hi_cnt + 1'b1);
      if (vld_o) nxt_ch <= nxt_ch + 1'b1;
    end
  end

  p_sck_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  p_setup_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> (lo_cnt >= CNT_W'(CS_SETUP)));
  p_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= CNT_W'(GAP_CYCLES)));
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $rose(cs_no));
  p_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  p_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (vld_ch_o == nxt_ch));
endmodule

bind adc_scanner adc_scanner_chk #(.CS_SETUP(CS_SETUP), .GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_no(cs_no), .sck_o(sck_o),
  .vld_o(vld_o), .vld_ch_o(vld_ch_o)
);

// File: tb/tb_adc_scanner.sv
`timescale 1ns/1ps
module tb_adc_scanner;
  localparam int GAP  = 25;
  localparam int SETUP = 13;
  localparam logic [15:0] RESP [16] = '{
    16'hFC00, 16'hA801, 16'h5555, 16'h03FF, 16'hF2AA, 16'h8123, 16'h7E00, 16'hC1FE,
    16'h0400, 16'hFFFF, 16'h2C7D, 16'h9302, 16'hE0F0, 16'h4B4B, 16'hD19A, 16'h1800
  };

  logic clk_i = 0, rst_ni = 0, en_i = 0;
  logic sck_o, mosi_o, miso_i, cs_no, vld_o;
  logic [2:0]  rd_ch_i = 0, vld_ch_o;
  logic [15:0] rd_data_o;

  always #10 clk_i = ~clk_i;

  adc_scanner dut (
    .clk_i, .rst_ni, .en_i, .sck_o, .mosi_o, .miso_i, .cs_no,
    .rd_ch_i, .rd_data_o, .vld_o, .vld_ch_o
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // converter model
  int frame_cnt = 0, bitk = 0;
  logic [15:0] rx_cmd = 0;
  logic [15:0] cmd_log [64];
  always @(posedge sck_o or posedge cs_no) begin
    if (cs_no) begin
      if (rst_ni) begin
        cmd_log[frame_cnt % 64] = rx_cmd;
        frame_cnt++;
      end
      bitk = 0;
      rx_cmd = 0;
    end else begin
      rx_cmd = {rx_cmd[14:0], mosi_o};
      bitk++;
    end
  end
  assign miso_i = (bitk < 16) ? RESP[frame_cnt % 16][15 - bitk] : 1'b0;

  // timing monitor
  int hi_cnt = 0, lo_cnt = 0, last_gap = 0, setup_seen = 0, sh = 0, sck_hi_len = 0, low_total = 0;
  bit prev_cs = 1, sck_seen = 0;
  always @(negedge clk_i) begin
    if (cs_no) begin
      hi_cnt++; lo_cnt = 0; sck_seen = 0;
    end else begin
      if (prev_cs) last_gap = hi_cnt;
      hi_cnt = 0;
      low_total++;
      if (!sck_seen) begin
        if (sck_o) begin setup_seen = lo_cnt; sck_seen = 1; end
        else lo_cnt++;
      end
    end
    if (sck_o) sh++;
    else if (sh != 0) begin sck_hi_len = sh; sh = 0; end
    prev_cs = cs_no;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_vld(output bit got);
    got = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk_i);
      if (vld_o) begin got = 1; break; end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
    end
  end

  initial begin
    bit got;
    int snap;
    logic [15:0] exp_cmd;
    repeat (5) @(negedge clk_i);
    // R1 reset state
    chk(cs_no == 1'b1, "R1 cs", cs_no, 1);
    chk(sck_o == 1'b0, "R1 sck", sck_o, 0);
    rst_ni = 1;
    for (int c = 0; c < 8; c++) begin
      rd_ch_i = 3'(c); #1;
      chk(rd_data_o == 16'hFFFF, "R1 result", rd_data_o, 16'hFFFF);
    end
    // R2 idle while disabled
    snap = low_total;
    repeat (60) @(negedge clk_i);
    chk(low_total == snap, "R2 idle cs", low_total - snap, 0);
    en_i = 1;

    // vector walk: two full rotations
    for (int i = 0; i < 16; i++) begin
      wait_vld(got);
      chk(got, "R3 strobe seen", got, 1);
      chk(vld_ch_o == 3'(i % 8), "R3 order", vld_ch_o, i % 8);
      chk(cs_no == 1'b1, "R8 cs released", cs_no, 1);
      exp_cmd = 16'h0100 | 16'((i % 8) << 4);
      chk(cmd_log[i] == exp_cmd, "R4 command", cmd_log[i], exp_cmd);
      rd_ch_i = 3'(i % 8); #1;
      chk(rd_data_o == {6'b0, RESP[i][9:0]}, "R6 stored", rd_data_o, {6'b0, RESP[i][9:0]});
      if (i == 0) begin
        rd_ch_i = 3'd5; #1;
        chk(rd_data_o == 16'hFFFF, "R11 unconverted", rd_data_o, 16'hFFFF);
      end
      chk(setup_seen >= SETUP, "R7 setup", setup_seen, SETUP);
      chk(sck_hi_len == 2, "R5 sck high", sck_hi_len, 2);
      if (i >= 1) chk(last_gap == GAP, "R9 gap", last_gap, GAP);
      @(negedge clk_i);
      chk(vld_o == 1'b0, "R3 one-cycle", vld_o, 0);
    end

    // R10 disable inside a frame
    for (int k = 0; k < 500 && cs_no; k++) @(negedge clk_i);
    repeat (20) @(negedge clk_i);
    en_i = 0;
    wait_vld(got);
    chk(got && vld_ch_o == 3'd0, "R10 frame finishes", vld_ch_o, 0);
    rd_ch_i = 3'd0; #1;
    chk(rd_data_o == {6'b0, RESP[0][9:0]}, "R10 data", rd_data_o, {6'b0, RESP[0][9:0]});
    snap = low_total;
    repeat (300) @(negedge clk_i);
    chk(low_total == snap, "R10 parked", low_total - snap, 0);
    en_i = 1;
    wait_vld(got);
    chk(got && vld_ch_o == 3'd1, "R10 resume", vld_ch_o, 1);
    rd_ch_i = 3'd1; #1;
    chk(rd_data_o == {6'b0, RESP[1][9:0]}, "R10 resume data", rd_data_o, {6'b0, RESP[1][9:0]});

    done_flag = 1;
    summary();
  end
endmodule